// File: doc/BRIEF.md
# Synchronous SRAM Port Control

This block is the control core of a single-clock synchronous static RAM with a shared bidirectional data bus. On each clock edge that the clock enable lets through, it decodes three chip enables and the write enable into a read, a write or a deselect. It then either loads a read data register from a small internal array, or records a write so that the data can be taken from the bus on the following recognised edge. The array is written one byte lane at a time, and each lane carries a parity bit that travels with its byte.

The bus enable output decides whether the data bus drives or floats. It combines the asynchronous output enable with internal conditions that override it: a write data phase, the first cycle after the device leaves an idle period, the deselected state, and sleep. A sleep input stops new accesses and keeps the stored contents intact. Burst address generation is done outside this block.

Top module: `sram_port_ctrl`

## Requirements
- R1: The device counts as selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at a recognised edge. Any other combination is a deselect: it performs no read and no write, and `dq_oe` is low in the following cycle.
- R2: A read is a recognised edge with the device selected, `sleep` low and `we_n` high. In the cycle after that edge, `{dqp_out,dq_out}` holds the word at `addr`. `dq_oe` is high in that cycle when `oe_n` is low and R7 does not apply.
- R3: A write is a recognised edge with the device selected, `sleep` low and `we_n` low. The block records `addr` and `bw_n` at that edge. `{dqp_in,dq_in}` is stored at the next recognised edge into every lane i whose `bw_n[i]` was 0. Lane i is `dq[8i+7:8i]` together with parity bit `dqp[i]`.
- R4: Byte strobes have no effect unless `we_n` is low. A read issued with `bw_n` low leaves the array unchanged.
- R5: `dq_oe` is low at once, with no clock edge needed, whenever `oe_n` is high.
- R6: `dq_oe` stays low during the write data phase, which is the cycle after a write command, whatever the level of `oe_n`.
- R7: After a recognised edge that ends an idle period, `dq_oe` is low for one cycle. An idle period is a deselect, a sleep-blocked edge, or reset. A read issued at that edge therefore updates `dq_out` but does not drive the bus.
- R8: A clock edge with `clk_en_n` high is ignored. All state holds, including `dq_out`, `dq_oe` and a pending write, which completes at the next recognised edge.
- R9: While `sleep` is high, `dq_oe` is low at once. Read and write commands are ignored, and a pending write whose data edge falls in sleep is dropped. The array contents are preserved.
- R10: A read of the address whose write completes at the same edge returns the new bytes in the strobed lanes and the old bytes in the other lanes.
- R11: After synchronous reset, `dq_oe`=0 and `{dqp_out,dq_out}`=0, and the next recognised edge is treated as ending an idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high masks the edge |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | LANES | Byte lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*BYTE_W | Data bus, incoming value |
| dqp_in | input | LANES | Parity bits, incoming value |
| dq_out | output | LANES*BYTE_W | Read data toward the bus |
| dqp_out | output | LANES | Read parity toward the bus |
| dq_oe | output | 1 | Bus drive enable for data and parity |

## Verification
The hardest states to reach are the ones where two mechanisms meet on the same edge. One is a read whose address matches a partial-lane write that is completing at that edge. The other is a write whose data edge is stalled by the clock enable, or cancelled by sleep. The stimulus reaches the first by issuing a write with a single lane strobed and then a read of the same address on the very next cycle. It reaches the second by putting a masked edge, or a sleep edge, between a write command and its data, then reading the word back twice, so that the result shows in the array and not only through forwarding. The idle-exit mask is reached after each of the three ways into idle: deselect, sleep and reset. The asynchronous gates are toggled between edges while the clock is masked, so that only the combinational path can change `dq_oe`.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared command type and select decode for the SRAM port control.
// Assumes: the three chip enables have fixed polarities (low, high, low).
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // True when all three chip enables are at their active level.
    function automatic logic chip_selected(input logic ce1_n, input logic ce2,
                                           input logic ce3_n);
        return !ce1_n && ce2 && !ce3_n;
    endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
// Module: decodes chip enables, write enable and strobes into a command on each
// recognised edge, and keeps the phase state (read, write data, idle exit).
// Assumes: clk_en_n high freezes every register here; sleep blocks commands.
module sram_cmd_decode
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_now,
    output logic              commit,
    output logic              rd_phase,
    output logic              wr_phase,
    output logic              first_phase,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_lanes
);

    logic edge_en;
    logic active;
    op_e  op_now;
    logic idle_q;

    // Classify the command presented at this edge.
    always_comb begin
        edge_en = !clk_en_n;
        active  = chip_selected(ce1_n, ce2, ce3_n) && !sleep;
        if (!active)   op_now = OP_NONE;
        else if (we_n) op_now = OP_READ;
        else           op_now = OP_WRITE;
    end

    // Register phase state and the write target on recognised edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_phase    <= 1'b0;
            wr_phase    <= 1'b0;
            first_phase <= 1'b0;
            idle_q      <= 1'b1;
            wr_addr     <= '0;
            wr_lanes    <= '0;
        end else if (edge_en) begin
            rd_phase    <= (op_now == OP_READ);
            wr_phase    <= (op_now == OP_WRITE);
            first_phase <= (op_now != OP_NONE) && idle_q;
            idle_q      <= (op_now == OP_NONE);
            if (op_now == OP_WRITE) begin
                wr_addr  <= addr;
                wr_lanes <= ~bw_n;
            end
        end
    end

    // A read loads its data now; a pending write lands unless sleep cancels it.
    always_comb begin
        rd_now = edge_en && (op_now == OP_READ);
        commit = edge_en && wr_phase && !sleep;
    end

endmodule

// File: rtl/sram_lane_store.sv
// Module: storage and read register for one byte lane (data byte plus parity).
// Assumes: at most one write and one read per edge; a read of the word being
// written at the same edge sees the new value of this lane.
module sram_lane_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_src;

    // Array write; contents are not reset so data survives sleep.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Pick stored data, or the lane being written at this same edge.
    always_comb begin
        if (wr_en && (wr_addr == rd_addr)) rd_src = wr_data;
        else                               rd_src = mem[rd_addr];
    end

    // Read data register, loaded only by a read command.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_src;
    end

endmodule

// File: rtl/sram_bus_drive.sv
// Module: decides whether the shared data bus drives.
// Assumes: oe_n and sleep are asynchronous and gate the result directly; the
// internal phase flags override oe_n.
module sram_bus_drive (
    input  logic oe_n,
    input  logic sleep,
    input  logic rd_phase,
    input  logic wr_phase,
    input  logic first_phase,
    output logic drive
);

    // Drive only read data, never in write, idle-exit or sleep cycles.
    always_comb begin
        drive = rd_phase && !wr_phase && !first_phase && !oe_n && !sleep;
    end

endmodule

// File: rtl/sram_port_ctrl.sv
// Module: top of the SRAM port control. Ties together command decode, one
// storage lane per byte strobe, and bus drive control.
// Assumes: a single clock; data taken from dq_in one recognised edge after a
// write command; read data presented one cycle after the read command.
module sram_port_ctrl #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*BYTE_W-1:0] dq_in,
    input  logic [LANES-1:0]        dqp_in,
    output logic [LANES*BYTE_W-1:0] dq_out,
    output logic [LANES-1:0]        dqp_out,
    output logic                    dq_oe
);

    localparam int LANE_W = BYTE_W + 1;

    logic              rd_now;
    logic              commit;
    logic              rd_phase;
    logic              wr_phase;
    logic              first_phase;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_lanes;

    sram_cmd_decode #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_en_n    (clk_en_n),
        .ce1_n       (ce1_n),
        .ce2         (ce2),
        .ce3_n       (ce3_n),
        .we_n        (we_n),
        .bw_n        (bw_n),
        .sleep       (sleep),
        .addr        (addr),
        .rd_now      (rd_now),
        .commit      (commit),
        .rd_phase    (rd_phase),
        .wr_phase    (wr_phase),
        .first_phase (first_phase),
        .wr_addr     (wr_addr),
        .wr_lanes    (wr_lanes)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_wdata;
        logic [LANE_W-1:0] lane_rdata;

        // Parity bit rides above its byte so both share one strobe.
        always_comb lane_wdata = {dqp_in[g], dq_in[g*BYTE_W +: BYTE_W]};

        sram_lane_store #(
            .ADDR_W (ADDR_W),
            .WORD_W (LANE_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (commit && wr_lanes[g]),
            .wr_addr (wr_addr),
            .wr_data (lane_wdata),
            .rd_en   (rd_now),
            .rd_addr (addr),
            .rd_data (lane_rdata)
        );

        // Split the lane word back onto data and parity outputs.
        always_comb begin
            dq_out[g*BYTE_W +: BYTE_W] = lane_rdata[BYTE_W-1:0];
            dqp_out[g]                 = lane_rdata[BYTE_W];
        end
    end

    sram_bus_drive u_drive (
        .oe_n        (oe_n),
        .sleep       (sleep),
        .rd_phase    (rd_phase),
        .wr_phase    (wr_phase),
        .first_phase (first_phase),
        .drive       (dq_oe)
    );

endmodule

// File: rtl/sram_port_ctrl_chk.sv
// Checker: temporal properties of the SRAM port control, seen at its ports.
// Assumes: attached to every instance of sram_port_ctrl through the bind below.
module sram_port_ctrl_chk #(
    parameter int LANES  = 2,
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clk_en_n,
    input logic                    ce1_n,
    input logic                    ce2,
    input logic                    ce3_n,
    input logic                    we_n,
    input logic                    oe_n,
    input logic                    sleep,
    input logic [LANES*BYTE_W-1:0] dq_out,
    input logic [LANES-1:0]        dqp_out,
    input logic                    dq_oe
);

    logic sel;
    always_comb sel = !ce1_n && ce2 && !ce3_n;

    a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sel) |=> !dq_oe);

    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && sel && !sleep && we_n) ##1
        (!clk_en_n && sel && !sleep && we_n) |=> (dq_oe == (!oe_n && !sleep)));

    a_r5_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    a_r6_write_phase_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && sel && !sleep && !we_n) |=> !dq_oe);

    a_r7_idle_exit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sel) ##1 (!clk_en_n && sel && !sleep) |=> !dq_oe);

    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(dq_out) && $stable(dqp_out)));

    a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .dq_out   (dq_out),
    .dqp_out  (dqp_out),
    .dq_oe    (dq_oe)
);

// File: tb/sim_sram_port_ctrl.sv
// Bench: vector table walked by one loop, then directed reset and corner tests.
module sim_sram_port_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        ce1_n = 1'b1;
    logic        ce2 = 1'b1;
    logic        ce3_n = 1'b0;
    logic        we_n = 1'b1;
    logic [1:0]  bw_n = 2'b11;
    logic        oe_n = 1'b1;
    logic        sleep = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [1:0]  dqp_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dqp_out;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sram_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n),
        .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n),
        .sleep(sleep), .addr(addr), .dq_in(dq_in), .dqp_in(dqp_in),
        .dq_out(dq_out), .dqp_out(dqp_out), .dq_oe(dq_oe)
    );

    typedef struct packed {
        logic [2:0]  ce;      // {ce1_n, ce2, ce3_n}; 3'b010 selects
        logic        we;
        logic [1:0]  bw;
        logic [5:0]  a;
        logic [17:0] d;       // {dqp, dq}
        logic        oe;
        logic        cen;
        logic        slp;
        logic        chk_oe;
        logic        exp_oe;
        logic        chk_d;
        logic [17:0] exp_d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'b110,1'b1,2'b11,6'd0,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,18'h00000,4'd1},  // R1 deselect
        '{3'b010,1'b0,2'b00,6'd5,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,18'h00000,4'd7},  // R7 exit idle
        '{3'b010,1'b0,2'b00,6'd6,18'h1A5C3,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,18'h00000,4'd6},  // R6 write phase
        '{3'b010,1'b1,2'b11,6'd5,18'h23C7E,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,18'h1A5C3,4'd2},  // R2 read
        '{3'b010,1'b1,2'b11,6'd6,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,18'h23C7E,4'd3},  // R3 parity bits
        '{3'b010,1'b1,2'b11,6'd6,18'h00000,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,18'h23C7E,4'd5},  // R5 oe_n high
        '{3'b010,1'b0,2'b10,6'd5,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,18'h00000,4'd6},  // R6 lane 0 only
        '{3'b010,1'b1,2'b11,6'd5,18'h3FFEE,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,18'h1A5EE,4'd10}, // R10 forward
        '{3'b010,1'b1,2'b00,6'd5,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,18'h1A5EE,4'd4},  // R4 strobes on read
        '{3'b010,1'b1,2'b11,6'd5,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,18'h1A5EE,4'd4},  // R4 unchanged
        '{3'b010,1'b1,2'b11,6'd6,18'h00000,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,18'h1A5EE,4'd8},  // R8 masked edge
        '{3'b110,1'b1,2'b11,6'd5,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,18'h00000,4'd1},  // R1 ce1_n high
        '{3'b011,1'b0,2'b00,6'd6,18'h3FFFF,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,18'h00000,4'd1},  // R1 ce3_n high
        '{3'b010,1'b1,2'b11,6'd6,18'h3FFFF,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,18'h23C7E,4'd7},  // R7 exit idle
        '{3'b010,1'b1,2'b11,6'd6,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,18'h23C7E,4'd1},  // R1 no write
        '{3'b000,1'b1,2'b11,6'd6,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,18'h00000,4'd1},  // R1 ce2 low
        '{3'b010,1'b1,2'b11,6'd5,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,18'h1A5EE,4'd7},  // R7 exit idle
        '{3'b010,1'b1,2'b11,6'd5,18'h00000,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,18'h1A5EE,4'd2}   // R2 read
    };

    // Compare outputs with expectations and report any mismatch.
    task automatic check_out(input string req, input logic c_oe, input logic e_oe,
                             input logic c_d, input logic [17:0] e_d);
        if (c_oe) begin
            checks++;
            if (dq_oe !== e_oe) begin
                errors++;
                $display("FAIL %s: dq_oe=%0b expected %0b at %0t", req, dq_oe, e_oe, $time);
            end
        end
        if (c_d) begin
            checks++;
            if ({dqp_out, dq_out} !== e_d) begin
                errors++;
                $display("FAIL %s: data=%05h expected %05h at %0t", req,
                         {dqp_out, dq_out}, e_d, $time);
            end
        end
    endtask

    // Apply one cycle of inputs at a falling edge and return at the next one.
    task automatic step(input logic [2:0] ce, input logic we, input logic [1:0] bw,
                        input logic [5:0] a, input logic [17:0] d, input logic oe,
                        input logic cen, input logic slp);
        {ce1_n, ce2, ce3_n} = ce;
        we_n = we; bw_n = bw; addr = a; {dqp_in, dq_in} = d;
        oe_n = oe; clk_en_n = cen; sleep = slp;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check_out("R11", 1'b1, 1'b0, 1'b1, 18'h00000);   // R11 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].ce, VECS[i].we, VECS[i].bw, VECS[i].a, VECS[i].d,
                 VECS[i].oe, VECS[i].cen, VECS[i].slp);
            check_out($sformatf("R%0d", VECS[i].req), VECS[i].chk_oe, VECS[i].exp_oe,
                      VECS[i].chk_d, VECS[i].exp_d);
        end

        // R9: a write whose data edge falls in sleep is dropped, data kept.
        step(3'b010, 1'b0, 2'b00, 6'd7, 18'h00000, 1'b0, 1'b0, 1'b0);
        check_out("R6", 1'b1, 1'b0, 1'b0, 18'h0);
        step(3'b010, 1'b1, 2'b11, 6'd7, 18'h21234, 1'b0, 1'b0, 1'b0);
        check_out("R3", 1'b1, 1'b1, 1'b1, 18'h21234);
        step(3'b010, 1'b0, 2'b00, 6'd7, 18'h00000, 1'b0, 1'b0, 1'b0);
        step(3'b010, 1'b1, 2'b11, 6'd7, 18'h0BEEF, 1'b0, 1'b0, 1'b1);
        check_out("R9", 1'b1, 1'b0, 1'b0, 18'h0);
        step(3'b010, 1'b1, 2'b11, 6'd7, 18'h00000, 1'b0, 1'b0, 1'b0);
        check_out("R9", 1'b1, 1'b0, 1'b1, 18'h21234);   // R7 after sleep, data kept
        step(3'b010, 1'b1, 2'b11, 6'd7, 18'h00000, 1'b0, 1'b0, 1'b0);
        check_out("R9", 1'b1, 1'b1, 1'b1, 18'h21234);

        // R9 and R5: asynchronous gating while the clock edge is masked.
        clk_en_n = 1'b1; sleep = 1'b1;
        #1 check_out("R9", 1'b1, 1'b0, 1'b0, 18'h0);
        @(posedge clk); @(negedge clk);
        sleep = 1'b0;
        #1 check_out("R8", 1'b1, 1'b1, 1'b1, 18'h21234);
        oe_n = 1'b1;
        #1 check_out("R5", 1'b1, 1'b0, 1'b0, 18'h0);
        oe_n = 1'b0;
        #1 check_out("R5", 1'b1, 1'b1, 1'b0, 18'h0);
        @(negedge clk);

        // R8: a pending write waits across a masked edge for its data.
        step(3'b010, 1'b0, 2'b00, 6'd9, 18'h00000, 1'b0, 1'b0, 1'b0);
        step(3'b010, 1'b1, 2'b11, 6'd9, 18'h30000, 1'b0, 1'b1, 1'b0);
        check_out("R8", 1'b1, 1'b0, 1'b0, 18'h0);
        step(3'b010, 1'b1, 2'b11, 6'd9, 18'h05A5A, 1'b0, 1'b0, 1'b0);
        check_out("R8", 1'b1, 1'b1, 1'b1, 18'h05A5A);
        step(3'b010, 1'b1, 2'b11, 6'd9, 18'h00000, 1'b0, 1'b0, 1'b0);
        check_out("R8", 1'b1, 1'b1, 1'b1, 18'h05A5A);

        // R11: mid-run reset clears outputs and arms the idle-exit mask.
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check_out("R11", 1'b1, 1'b0, 1'b1, 18'h00000);
        rst_n = 1'b1;
        step(3'b010, 1'b1, 2'b11, 6'd9, 18'h00000, 1'b0, 1'b0, 1'b0);
        check_out("R11", 1'b1, 1'b0, 1'b1, 18'h05A5A);
        step(3'b010, 1'b1, 2'b11, 6'd9, 18'h00000, 1'b0, 1'b0, 1'b0);
        check_out("R2", 1'b1, 1'b1, 1'b1, 18'h05A5A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule